// File: doc/BRIEF.md
# Two-Channel Minimum-Width Pulse Counter

This block counts pulses on two independent asynchronous inputs and keeps a separate event count per channel. An input is idle high; a pulse is the low phase that begins with a falling edge and ends with the next rising edge. A pulse adds to its channel's count only if it stays low for at least a programmable number of clock cycles. With a 100 MHz clock, the default of 200 cycles corresponds to a 2 µs minimum width. Pulses in normal use last between 2 and 10 µs. Shorter glitches are discarded.

Each channel has a width timer. The timer is held at zero while the synchronized input is high and counts clock cycles while it is low. The count is bumped as soon as the timer reaches the threshold, in the middle of the pulse. No timestamps are taken and nothing is subtracted. Once the timer has fired it stops, so a pulse of any length is counted exactly once. The threshold is taken from its input only while a channel is idle. A change made during a pulse therefore affects only later pulses.

Top module: `pwq_counter`

## Requirements
- R1: The two channels are independent: activity on one input never changes the other channel's count or strobe.
- R2: A channel counts a pulse only if its input is sampled low on at least T consecutive clock edges after synchronization, where T is the latched threshold. A low run shorter than T leaves the count unchanged, and the count changes at no other time.
- R3: Each input passes through a two-flop synchronizer. If an input is first low at clock edge k and stays low, the count and strobe update at edge k+1+T.
- R4: The increment happens while the pulse is still low. A pulse held low for any length beyond T adds exactly one.
- R5: `qual_stb_o[ch]` is high for exactly one cycle per qualified pulse. That cycle is the first cycle in which the channel's count shows the incremented value.
- R6: Each count is 16 bits wide and wraps from 65535 to 0.
- R7: `count_clr_i` clears both counts at the next clock edge. It takes priority over an increment at that same edge.
- R8: The threshold is latched from `min_width_i` only while a channel's synchronized input is high. A change of `min_width_i` during a pulse does not alter how that pulse is judged.
- R9: A threshold of 0 behaves as a threshold of 1.
- R10: After synchronous active-low reset, both counts and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_n_i | input | 2 | Asynchronous pulse inputs, low = active; bit 0 is channel 0 |
| min_width_i | input | 16 | Minimum low width in clock cycles |
| count_clr_i | input | 1 | Synchronous clear of both counts |
| count_o | output | 32 | Event counts; bits [15:0] channel 0, bits [31:16] channel 1 |
| qual_stb_o | output | 2 | One-cycle qualified-pulse strobe per channel |

## Verification
The embedded assertions check four properties on every cycle:
- a strobe never lasts more than one cycle;
- a strobe only follows a low synchronized input;
- a count moves by exactly one on an increment and otherwise holds;
- a clear always lands on zero.

Other behaviours need a reference model running alongside the design:
- the exact latency from a falling edge to the increment;
- the rejection of runs one cycle short of the threshold;
- the freezing of the threshold during a pulse;
- the zero-threshold case;
- the 16-bit wrap.

The bench shows these through directed scenarios, each compared against the behavioural reference model on every clock.

// File: rtl/pwq_pkg.sv
// Package: shared constants and the width-timer state type for the
// two-channel minimum-width pulse counter.
package pwq_pkg;
    localparam int unsigned PWQ_NCH     = 2;
    localparam int unsigned PWQ_THR_W   = 16;
    localparam int unsigned PWQ_CNT_W   = 16;
    localparam int unsigned PWQ_DEF_THR = 200;   // 2 us at 100 MHz

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,   // input high, threshold tracking
        TS_TIMING = 2'd1,   // input low, below threshold
        TS_DONE   = 2'd2    // pulse already counted
    } tmr_state_e;
endpackage

// File: rtl/pwq_sync.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes: d_i is fully asynchronous to clk; RST_VAL is the idle level.
module pwq_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic stab_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/pwq_width_timer.sv
// Width timer for one channel. The timer is held at zero while the
// channel is idle and counts active cycles otherwise. It raises hit_o in
// the cycle the count reaches the latched threshold, then stops until
// the input goes idle again.
// Assumes: active_i is already synchronized; a threshold of 0 is taken as 1.
module pwq_width_timer
    import pwq_pkg::*;
#(
    parameter int unsigned THR_W   = PWQ_THR_W,
    parameter int unsigned DEF_THR = PWQ_DEF_THR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [THR_W-1:0] min_width_i,
    output logic             hit_o,
    output logic             qual_o
);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);
    localparam logic [THR_W-1:0] THR_ONE = THR_W'(1);

    tmr_state_e       state_q;
    logic [THR_W-1:0] timer_q;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] eff_thr;
    logic [THR_W:0]   next_cnt;

    // Effective threshold: zero is promoted to one.
    always_comb begin
        eff_thr = (thr_q == '0) ? THR_ONE : thr_q;
    end

    // Next timer value and the qualification decision.
    always_comb begin
        next_cnt = {1'b0, timer_q} + {{THR_W{1'b0}}, 1'b1};
        hit_o    = active_i && (state_q != TS_DONE) &&
                   (next_cnt >= {1'b0, eff_thr});
    end

    // Timer, state, threshold latch and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            timer_q <= '0;
            thr_q   <= THR_RST;
            qual_o  <= 1'b0;
        end else begin
            qual_o <= hit_o;
            if (!active_i) begin
                state_q <= TS_IDLE;
                timer_q <= '0;
                thr_q   <= min_width_i;
            end else if (state_q != TS_DONE) begin
                timer_q <= next_cnt[THR_W-1:0];
                state_q <= hit_o ? TS_DONE : TS_TIMING;
            end
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> !qual_o);  // R5

    AST_STB_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(active_i));  // R2
endmodule

// File: rtl/pwq_event_counter.sv
// Wrapping event counter for one channel with a synchronous clear.
// Assumes: inc_i is high for at most one cycle per event; clear wins.
module pwq_event_counter
    import pwq_pkg::*;
#(
    parameter int unsigned CNT_W = PWQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    // Clear has priority; otherwise step by one with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (count_o == CNT_W'($past(count_o) + CNT_W'(1))));  // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));  // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(count_o));  // R2
endmodule

// File: rtl/pwq_counter.sv
// Two-channel minimum-width pulse counter. Each active-low input is
// synchronized, timed while low and counted once when its low phase
// reaches the threshold.
// Assumes: inputs idle high; count_o packs channel ch at [ch*CNT_W +: CNT_W].
module pwq_counter
    import pwq_pkg::*;
#(
    parameter int unsigned NCH     = PWQ_NCH,
    parameter int unsigned THR_W   = PWQ_THR_W,
    parameter int unsigned CNT_W   = PWQ_CNT_W,
    parameter int unsigned DEF_THR = PWQ_DEF_THR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       pulse_n_i,
    input  logic [THR_W-1:0]     min_width_i,
    input  logic                 count_clr_i,
    output logic [NCH*CNT_W-1:0] count_o,
    output logic [NCH-1:0]       qual_stb_o
);
    logic [NCH-1:0] sync_lvl;
    logic [NCH-1:0] active;
    logic [NCH-1:0] hit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwq_sync #(.RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pulse_n_i[ch]),
            .q_o   (sync_lvl[ch])
        );

        assign active[ch] = ~sync_lvl[ch];

        pwq_width_timer #(.THR_W(THR_W), .DEF_THR(DEF_THR)) u_timer (
            .clk         (clk),
            .rst_n       (rst_n),
            .active_i    (active[ch]),
            .min_width_i (min_width_i),
            .hit_o       (hit[ch]),
            .qual_o      (qual_stb_o[ch])
        );

        pwq_event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (count_clr_i),
            .inc_i   (hit[ch]),
            .count_o (count_o[ch*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/sim_pwq_counter.sv
// Bench for pwq_counter. A behavioural reference model is compared on
// every clock, and directed scenarios add requirement-specific checks.
module sim_pwq_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b11;
    logic [15:0] min_width = 16'd200;
    logic        clr = 1'b0;
    logic [31:0] count;
    logic [1:0]  stb;

    int total = 0;
    int bad = 0;

    pwq_counter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_n_i   (pin),
        .min_width_i (min_width),
        .count_clr_i (clr),
        .count_o     (count),
        .qual_stb_o  (stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    logic [1:0] hist[$];
    int  run_m[2];
    bit  done_m[2];
    int  thr_m[2];
    int  cnt_m[2];
    bit  stb_m[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{2'b11, 2'b11};
            for (int c = 0; c < 2; c++) begin
                run_m[c] = 0; done_m[c] = 0; thr_m[c] = 200;
                cnt_m[c] = 0; stb_m[c] = 0;
            end
        end else begin
            logic [1:0] lvl;
            lvl = hist[0];
            void'(hist.pop_front());
            hist.push_back(pin);
            for (int c = 0; c < 2; c++) begin
                bit hit;
                hit = 0;
                if (lvl[c]) begin
                    run_m[c] = 0; done_m[c] = 0; thr_m[c] = int'(min_width);
                end else if (!done_m[c]) begin
                    run_m[c]++;
                    if (run_m[c] >= ((thr_m[c] == 0) ? 1 : thr_m[c])) begin
                        hit = 1; done_m[c] = 1;
                    end
                end
                stb_m[c] = hit;
                if (clr) cnt_m[c] = 0;
                else if (hit) cnt_m[c] = (cnt_m[c] + 1) % 65536;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int cnt_of(int c);
        return int'(count[c*16 +: 16]);
    endfunction

    // Cycle-by-cycle comparison against the model (R1, R5).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                check($sformatf("R1 model count ch%0d", c), cnt_of(c), cnt_m[c]);
                check($sformatf("R5 model strobe ch%0d", c), int'(stb[c]), int'(stb_m[c]));
            end
        end
    end

    task automatic low_pulse(int c, int cycles);
        @(negedge clk); pin[c] = 1'b0;
        repeat (cycles) @(negedge clk);
        pin[c] = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base0;
        int base1;
        repeat (3) @(negedge clk);
        check("R10 reset count ch0", cnt_of(0), 0);
        check("R10 reset count ch1", cnt_of(1), 0);
        check("R10 reset strobe", int'(stb), 0);
        rst_n = 1'b1;
        min_width = 16'd5;
        repeat (3) @(negedge clk);

        // R3 latency and R4 single increment mid-pulse
        pin[0] = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 before edge k+1+T", cnt_of(0), 0);
        @(negedge clk);
        check("R3 at edge k+1+T", cnt_of(0), 1);
        check("R5 strobe high", int'(stb[0]), 1);
        @(negedge clk);
        check("R5 strobe one cycle", int'(stb[0]), 0);
        repeat (20) @(negedge clk);
        pin[0] = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 long pulse counted once", cnt_of(0), 1);
        check("R1 other channel untouched", cnt_of(1), 0);

        // R2 boundary: T-1 rejected, T accepted
        low_pulse(1, 4);
        check("R2 short pulse ignored", cnt_of(1), 0);
        low_pulse(1, 5);
        check("R2 pulse at threshold counted", cnt_of(1), 1);

        // R1 simultaneous pulses of differing widths
        @(negedge clk); pin = 2'b00;
        repeat (3) @(negedge clk); pin[0] = 1'b1;
        repeat (7) @(negedge clk); pin[1] = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 ch0 short unchanged", cnt_of(0), 1);
        check("R1 ch1 long counted", cnt_of(1), 2);

        // R8 threshold frozen during a pulse
        min_width = 16'd10;
        repeat (3) @(negedge clk);
        pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        min_width = 16'd100;
        repeat (10) @(negedge clk);
        pin[0] = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 pulse judged by old threshold", cnt_of(0), 2);
        low_pulse(0, 50);
        check("R8 new threshold applies next pulse", cnt_of(0), 2);

        // R9 zero threshold acts as one
        min_width = 16'd0;
        repeat (3) @(negedge clk);
        low_pulse(0, 1);
        check("R9 one-cycle pulse with T=0", cnt_of(0), 3);

        // R7 clear, and clear beating a simultaneous increment
        min_width = 16'd1;
        @(negedge clk); clr = 1'b1; pin[1] = 1'b0;
        repeat (6) @(negedge clk);
        clr = 1'b0; pin[1] = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 clear ch0", cnt_of(0), 0);
        check("R7 clear wins over increment", cnt_of(1), 0);

        // R6 wrap at 16 bits on both channels
        base0 = cnt_of(0);
        base1 = cnt_of(1);
        for (int i = 0; i < 65535; i++) begin
            pin = 2'b00; @(negedge clk);
            pin = 2'b11; @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R6 count at 65535 ch0", cnt_of(0), (base0 + 65535) % 65536);
        check("R6 count at 65535 ch1", cnt_of(1), (base1 + 65535) % 65536);
        pin = 2'b00; @(negedge clk);
        pin = 2'b11;
        repeat (4) @(negedge clk);
        check("R6 wrap ch0", cnt_of(0), base0);
        check("R6 wrap ch1", cnt_of(1), base1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule